// File: doc/BRIEF.md
# Programmable FFT Stage Scaling Unit

This block sits at the output of each butterfly stage in a fixed-point radix-4 FFT datapath. The datapath runs with scaled output. The block takes the full-precision complex result of a stage and divides it by a power of two chosen for that stage. It then narrows the result to the sample width. Each stage has a two-bit field in a packed schedule word, and that field selects a right shift of zero to three bits. The overall gain of the transform is therefore one over two raised to the sum of the fields. A full 9-bit growth, as in a 256-point transform, is exactly undone by fields of 3, 2, 2 and 2 (last stage first).

Software writes the schedule through a configuration port at any time. The block holds the word as pending. It becomes the active schedule only on the first sample of a frame, so a frame always runs with a single schedule. Samples whose scaled value does not fit the output width are flagged individually. Such samples pass through as wrapped two's-complement values, which matches a wrap-around reference model. A sticky per-frame overflow status is presented with the last output sample of each frame.

Top module: `fft_stage_scaler`

## Requirements
- R1: The field for stage k sits at schedule bits [2k+1:2k], so stage 0 is least significant and stage N_STAGES-1 most significant. A field value v shifts that stage's samples right by v bits (0 to 3).
- R2: The shift is arithmetic (sign-extending) and rounds toward negative infinity with no rounding correction. For example, -5 shifted by 2 gives -2.
- R3: Each output lane carries the low OUT_W bits of its shifted value, with no saturation.
- R4: A configuration write is held as pending and becomes active only when a valid sample with the first flag is accepted. A write made mid-frame, or in the same cycle as a first sample, applies from the following frame.
- R5: The per-sample overflow flag is high when the shifted real part or the shifted imaginary part lies outside the signed OUT_W range.
- R6: frame_ovf_o is high together with the last output sample of a frame exactly when some sample from that frame's first through its last overflowed. The status starts clear at each first sample.
- R7: Outputs appear one clock after the sample is accepted. m_valid_o and m_last_o follow s_valid_i and s_last_i, and m_ovf_o and frame_ovf_o are low while m_valid_o is low.
- R8: After reset, both the pending and the active schedule are zero (no shift), and m_valid_o, m_ovf_o and frame_ovf_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_valid_i | input | 1 | Schedule write strobe |
| cfg_sched_i | input | 2*N_STAGES | Packed schedule, two bits per stage |
| s_valid_i | input | 1 | Input sample valid |
| s_first_i | input | 1 | First sample of a frame |
| s_last_i | input | 1 | Last sample of a frame |
| s_stage_i | input | STG_W | Stage index of the sample |
| s_re_i | input | ACC_W | Full-precision real part, signed |
| s_im_i | input | ACC_W | Full-precision imaginary part, signed |
| m_valid_o | output | 1 | Output sample valid |
| m_last_o | output | 1 | Output sample is last of frame |
| m_re_o | output | OUT_W | Scaled real part |
| m_im_o | output | OUT_W | Scaled imaginary part |
| m_ovf_o | output | 1 | Per-sample overflow |
| frame_ovf_o | output | 1 | Sticky frame overflow, valid with m_last_o |

## Verification
The bench uses the default parameters: OUT_W of 16, four stages and ACC_W of 25. With these values the input span covers the full 9-bit growth of a 256-point transform. A 3,2,2,2 schedule therefore brings the widest values back into range, while smaller schedules or large inputs push them into overflow and wrap. Four stages also give each field position its own index, so a swapped field order shows up. Frames that mix mid-frame writes, same-cycle writes and overflow at the first, middle and last samples reach the pending/active hand-over and the clearing of the sticky status.

// File: rtl/fft_scale_pkg.sv
package fft_scale_pkg;
  typedef logic [1:0] shamt_t;
endpackage

// File: rtl/fft_sched_reg.sv
module fft_sched_reg
  import fft_scale_pkg::*;
#(
  parameter int N_STAGES = 4,
  parameter int STG_W    = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_valid_i,
  input  logic [2*N_STAGES-1:0]   cfg_sched_i,
  input  logic                    start_i,
  input  logic [STG_W-1:0]        stage_i,
  output shamt_t                  shamt_o
);
  typedef logic [N_STAGES-1:0][1:0] sched_t;

  sched_t pending_q, active_q, sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= '0;
      active_q  <= '0;
    end else begin
      if (cfg_valid_i) pending_q <= cfg_sched_i;
      if (start_i)     active_q  <= pending_q;
    end
  end

  // first sample of a frame already runs on the pending word
  always_comb begin
    sel     = start_i ? pending_q : active_q;
    shamt_o = '0;
    for (int k = 0; k < N_STAGES; k++)
      if (int'(stage_i) == k) shamt_o = sel[k];
  end

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid_i |=> $stable(pending_q)); // R4
  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(active_q)); // R4
endmodule

// File: rtl/fft_lane_scaler.sv
module fft_lane_scaler
  import fft_scale_pkg::*;
#(
  parameter int ACC_W = 25,
  parameter int OUT_W = 16
) (
  input  logic signed [ACC_W-1:0] din_i,
  input  shamt_t                  sh_i,
  output logic [OUT_W-1:0]        dout_o,
  output logic                    ovf_o
);
  localparam int HI_W = ACC_W - OUT_W + 1;

  logic signed [ACC_W-1:0] shifted;
  logic [HI_W-1:0]         hi;

  always_comb begin
    shifted = din_i >>> sh_i;
    dout_o  = shifted[OUT_W-1:0];
    hi      = shifted[ACC_W-1:OUT_W-1];
    // bits above the output sign must all copy it
    ovf_o   = (|hi) && !(&hi);
  end
endmodule

// File: rtl/fft_stage_scaler.sv
module fft_stage_scaler
  import fft_scale_pkg::*;
#(
  parameter int N_STAGES = 4,
  parameter int OUT_W    = 16,
  parameter int ACC_W    = OUT_W + 2 * N_STAGES + 1,
  parameter int STG_W    = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_valid_i,
  input  logic [2*N_STAGES-1:0] cfg_sched_i,
  input  logic                  s_valid_i,
  input  logic                  s_first_i,
  input  logic                  s_last_i,
  input  logic [STG_W-1:0]      s_stage_i,
  input  logic [ACC_W-1:0]      s_re_i,
  input  logic [ACC_W-1:0]      s_im_i,
  output logic                  m_valid_o,
  output logic                  m_last_o,
  output logic [OUT_W-1:0]      m_re_o,
  output logic [OUT_W-1:0]      m_im_o,
  output logic                  m_ovf_o,
  output logic                  frame_ovf_o
);
  localparam int NLANE = 2;
  localparam logic signed [ACC_W-1:0] OUT_MAX = (ACC_W'(1) <<< (OUT_W - 1)) - 1;
  localparam logic signed [ACC_W-1:0] OUT_MIN = -OUT_MAX - 1;

  shamt_t           shamt;
  logic [ACC_W-1:0] lane_in  [NLANE];
  logic [OUT_W-1:0] lane_out [NLANE];
  logic [NLANE-1:0] lane_ovf;
  logic             ovf_any, sticky_q, sticky_nxt;

  fft_sched_reg #(.N_STAGES(N_STAGES), .STG_W(STG_W)) u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_valid_i (cfg_valid_i),
    .cfg_sched_i (cfg_sched_i),
    .start_i     (s_valid_i & s_first_i),
    .stage_i     (s_stage_i),
    .shamt_o     (shamt)
  );

  assign lane_in[0] = s_re_i;
  assign lane_in[1] = s_im_i;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    fft_lane_scaler #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_lane (
      .din_i  ($signed(lane_in[g])),
      .sh_i   (shamt),
      .dout_o (lane_out[g]),
      .ovf_o  (lane_ovf[g])
    );
  end

  assign ovf_any    = |lane_ovf;
  assign sticky_nxt = (s_first_i ? 1'b0 : sticky_q) | ovf_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_valid_o   <= 1'b0;
      m_last_o    <= 1'b0;
      m_re_o      <= '0;
      m_im_o      <= '0;
      m_ovf_o     <= 1'b0;
      frame_ovf_o <= 1'b0;
      sticky_q    <= 1'b0;
    end else begin
      m_valid_o   <= s_valid_i;
      m_last_o    <= s_valid_i & s_last_i;
      m_ovf_o     <= s_valid_i & ovf_any;
      frame_ovf_o <= s_valid_i & s_last_i & sticky_nxt;
      if (s_valid_i) begin
        m_re_o   <= lane_out[0];
        m_im_o   <= lane_out[1];
        sticky_q <= sticky_nxt;
      end
    end
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_valid_i |=> m_valid_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_valid_o |-> !m_ovf_o && !frame_ovf_o); // R7
  AST_FRAME_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ovf_o |-> m_last_o && m_valid_o); // R6
  AST_LAST_FEEDS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_ovf_o && m_last_o |-> frame_ovf_o); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_valid_i && $signed(s_re_i) <= OUT_MAX && $signed(s_re_i) >= OUT_MIN &&
    $signed(s_im_i) <= OUT_MAX && $signed(s_im_i) >= OUT_MIN |=> !m_ovf_o); // R5
endmodule

// File: tb/fft_stage_scaler_test.sv
module fft_stage_scaler_test;
  localparam int NS = 4, OW = 16, AW = 25, SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 0; logic [2*NS-1:0] cfg_sched = '0;
  logic s_valid = 0, s_first = 0, s_last = 0;
  logic [SW-1:0] s_stage = '0;
  logic [AW-1:0] s_re = '0, s_im = '0;
  logic m_valid, m_last, m_ovf, frame_ovf;
  logic [OW-1:0] m_re, m_im;

  int checks = 0, fails = 0;
  logic [2*NS-1:0] pend = '0, act = '0;
  bit sticky = 0;

  always #5ns clk = ~clk;

  fft_stage_scaler #(.N_STAGES(NS), .OUT_W(OW), .ACC_W(AW), .STG_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(cfg_valid), .cfg_sched_i(cfg_sched),
    .s_valid_i(s_valid), .s_first_i(s_first), .s_last_i(s_last), .s_stage_i(s_stage),
    .s_re_i(s_re), .s_im_i(s_im), .m_valid_o(m_valid), .m_last_o(m_last),
    .m_re_o(m_re), .m_im_o(m_im), .m_ovf_o(m_ovf), .frame_ovf_o(frame_ovf));

  task automatic chk(input bit ok, input string tag, input longint a, input longint e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, a, e, $time);
    end
  endtask

  // one clock: drive after negedge, model, compare at next negedge
  task automatic step(input bit cv, input logic [2*NS-1:0] cw, input bit v, input bit f,
                      input bit l, input int stg, input longint re, input longint im,
                      input string tag);
    logic [2*NS-1:0] sel;
    longint sre, sim;
    int sh;
    bit e_ovf, nxt;
    logic [OW-1:0] ere, eim;
    cfg_valid = cv; cfg_sched = cw; s_valid = v; s_first = f; s_last = l;
    s_stage = SW'(stg); s_re = re[AW-1:0]; s_im = im[AW-1:0];
    sel = (v && f) ? pend : act;
    sh  = int'((sel >> (2 * stg)) & 3);
    sre = re >>> sh; sim = im >>> sh;
    ere = sre[OW-1:0]; eim = sim[OW-1:0];
    e_ovf = (sre > 32767) || (sre < -32768) || (sim > 32767) || (sim < -32768);
    nxt = (f ? 1'b0 : sticky) | e_ovf;
    @(posedge clk);
    if (v) begin
      if (f) act = pend;
      sticky = nxt;
    end
    if (cv) pend = cw;
    @(negedge clk);
    chk(m_valid == v, "R7 valid", m_valid, v);
    if (v) begin
      chk(m_re == ere, {tag, " re"}, m_re, ere);
      chk(m_im == eim, {tag, " im"}, m_im, eim);
      chk(m_ovf == e_ovf, "R5 ovf", m_ovf, e_ovf);
      chk(m_last == l, "R7 last", m_last, l);
      chk(frame_ovf == (l && nxt), "R6 frame", frame_ovf, l && nxt);
    end else begin
      chk(!m_ovf && !frame_ovf, "R7 idle flags", {m_ovf, frame_ovf}, 0);
    end
  endtask

  task automatic idle(); step(0, '0, 0, 0, 0, 0, 0, 0, "R7"); endtask

  function automatic longint rnd(input bit wide);
    logic [AW-1:0] r;
    r = AW'($urandom);
    if (!wide) r = AW'($signed(r[OW:0]));
    return longint'($signed(r));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!m_valid && !m_ovf && !frame_ovf, "R8 reset outputs", {m_valid, m_ovf, frame_ovf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 zero schedule: no shift at any stage
    step(0, '0, 1, 1, 0, 3, 1234, -77, "R8");
    step(0, '0, 1, 0, 1, 0, -32768, 32767, "R8");
    // R1 fields 3,2,2,2 (last stage in MSBs); R2 floor on negatives
    step(1, 8'hEA, 0, 0, 0, 0, 0, 0, "R7");
    step(0, '0, 1, 1, 0, 0, -5, 7, "R2");
    step(0, '0, 1, 0, 0, 1, -1, 9, "R2");
    step(0, '0, 1, 0, 0, 3, 262136, -262144, "R1");
    step(0, '0, 1, 0, 1, 2, 131071, -131072, "R1");
    // R4 mid-frame write of zero schedule: no effect until next frame
    step(0, '0, 1, 1, 0, 3, 8, 16, "R4");
    step(1, 8'h00, 1, 0, 0, 3, 8, 16, "R4");
    step(0, '0, 1, 0, 1, 0, -4, 4, "R4");
    step(0, '0, 1, 1, 0, 3, 8, 16, "R4");
    step(0, '0, 1, 0, 1, 1, 3, -3, "R4");
    // R4 write in same cycle as first sample applies next frame
    step(1, 8'hFF, 1, 1, 0, 2, 100, -100, "R4");
    step(0, '0, 1, 0, 1, 2, 100, -100, "R4");
    step(0, '0, 1, 1, 1, 2, 100, -100, "R4");
    // R3 wrap and R5/R6 overflow in mid frame, then clean frame clears status
    step(1, 8'h00, 0, 0, 0, 0, 0, 0, "R7");
    step(0, '0, 1, 1, 0, 0, 10, 10, "R3");
    step(0, '0, 1, 0, 0, 1, 40000, 5, "R3");
    step(0, '0, 1, 0, 1, 2, 1, 2, "R6");
    step(0, '0, 1, 1, 0, 0, 1, 2, "R6");
    step(0, '0, 1, 0, 1, 0, -1, -40000, "R3");
    step(0, '0, 1, 1, 1, 0, 3, 4, "R6");
    idle();
    // random frames, random schedules and write timing
    for (int fr = 0; fr < 60; fr++) begin
      bit wide;
      wide = (fr % 3) == 0;
      for (int i = 0; i < 16; i++) begin
        bit cv;
        cv = ($urandom % 8) == 0;
        step(cv, 8'($urandom), ($urandom % 5) != 0 || i == 0 || i == 15,
             i == 0, i == 15, i / 4, rnd(wide), rnd(wide), "R3");
      end
      if (fr % 4 == 0) idle();
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule